// File: doc/BRIEF.md
# Double-Buffered Parameter Register Bank

This block holds the parameter set used by a pair of image address generators. Software, or a small controller, writes one 12-bit word at a time into a bank of preload registers through a 4-bit address, a 12-bit data bus and an active-low write enable. None of these writes reaches the address generators. They keep working from a second, working copy of the bank until a transfer strobe, or an initialize pulse with autoload enabled, copies all sixteen preload words into the working copy on one clock edge. A new parameter set can therefore be staged while a frame is still in progress, and the generators never see a half-updated set.

Every control input is registered once before it is used. A write or transfer sampled on one rising edge takes effect on the next rising edge. A transfer and a write that take effect on the same edge do not interact: the transfer moves the preload contents as they stood before that write. The working set is presented as one flat vector, word i in bits [12*i+11 : 12*i]. Parameters wider than 12 bits occupy adjacent words, with the low part at the lower address. The working control word at address 7 is also decoded for a 2-bit mode field and an autoload bit. The bank has no clock-hold input, so a pipeline hold elsewhere in the system cannot block its writes or transfers.

Top module: `param_shadow_bank`

## Requirements
- R1: A synchronous active-high reset clears every preload word and every working word to zero. After reset, work_o reads zero, and a transfer with no writes in between still gives zero.
- R2: When wr_n is low on a sampled edge, wr_data goes into the preload word selected by wr_addr on the following edge. A later transfer shows it in that word of work_o.
- R3: When wr_n is high on a sampled edge, no preload word changes, whatever wr_addr and wr_data carry.
- R4: Writing a preload word never changes work_o.
- R5: When xfer is high on a sampled edge, all sixteen working words take their preload values together on the following edge.
- R6: When no transfer is requested, work_o holds its value.
- R7: When a write and a transfer are sampled on the same edge, the working set receives the preload contents from before that write. The new word reaches work_o only at the next transfer.
- R8: Bit 11 of the working word at address 7 is the autoload bit. While it is 1, a low-to-high change of the sampled init input triggers a transfer with the same one-edge latency as xfer. Holding init high triggers only one transfer. While the bit is 0, init has no effect.
- R9: mode_o always equals bits [1:0] of the working word at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Preload write enable, active low |
| wr_addr | input | 4 | Preload word address |
| wr_data | input | 12 | Preload write data |
| xfer | input | 1 | Copy all preload words into the working set |
| init | input | 1 | Initialize input; a rising edge transfers when autoload is set |
| work_o | output | 192 | Working parameter set, word i at bits [12*i+11:12*i] |
| mode_o | output | 2 | Mode field of the working control word |

## Verification
Seeded random traffic mixes writes to random addresses, idle cycles with wr_n high and random bus values, occasional transfers, and init pulses. This separates a transfer that copies the whole bank from one that copies a single word, and shows whether a write leaks into the working set. Directed cases cover the ordering of a write and a transfer sampled on the same edge, and a transfer straight after reset. They also cover init rising edges with the autoload bit both set and clear, and init held high for several cycles, which must give exactly one transfer.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
  // Decoded, registered control for one clock of the bank.
  typedef struct packed {
    logic we;       // preload write request (active high internally)
    logic xfer;     // explicit transfer request
    logic init;     // sampled initialize level
    logic init_d;   // sampled initialize level one cycle earlier
  } pbank_ctl_t;

  localparam int unsigned PB_DEF_ADDR_W    = 4;
  localparam int unsigned PB_DEF_DATA_W    = 12;
  localparam int unsigned PB_DEF_CTRL_ADDR = 7;
  localparam int unsigned PB_DEF_AUTO_BIT  = 11;
  localparam int unsigned PB_DEF_MODE_LSB  = 0;
  localparam int unsigned PB_MODE_W        = 2;
endpackage

// File: rtl/pbank_in_stage.sv
module pbank_in_stage
  import pbank_pkg::*;
#(
  parameter int unsigned ADDR_W = PB_DEF_ADDR_W,
  parameter int unsigned DATA_W = PB_DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  input  logic              init,
  output pbank_ctl_t        ctl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ctl_q.we     <= ~wr_n;
      ctl_q.xfer   <= xfer;
      ctl_q.init   <= init;
      ctl_q.init_d <= ctl_q.init;
      addr_q       <= wr_addr;
      data_q       <= wr_data;
    end
  end

  // The delayed init copy must trail the sampled one by exactly one cycle.
  AST_INIT_DELAY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ctl_q.init_d == $past(ctl_q.init)) else $error("init delay"); // R8
endmodule

// File: rtl/pbank_preload.sv
module pbank_preload #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned NWORDS = 1 << ADDR_W,
  localparam int unsigned FLAT_W = NWORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [FLAT_W-1:0] pre_flat
);
  logic [DATA_W-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= data;
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_flat
    assign pre_flat[g*DATA_W +: DATA_W] = mem[g];
  end

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(pre_flat)) else $error("preload changed without write"); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> pre_flat[$past(addr)*DATA_W +: DATA_W] == $past(data)) else $error("write lost"); // R2
endmodule

// File: rtl/pbank_working.sv
module pbank_working #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned NWORDS = 1 << ADDR_W,
  localparam int unsigned FLAT_W = NWORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FLAT_W-1:0] pre_flat,
  output logic [FLAT_W-1:0] work_flat
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)       word_q <= '0;
      else if (load) word_q <= pre_flat[g*DATA_W +: DATA_W];
    end
    assign work_flat[g*DATA_W +: DATA_W] = word_q;
  end

  AST_HOLD_NO_XFER: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(work_flat)) else $error("working set drifted"); // R6
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
    load |=> work_flat == $past(pre_flat)) else $error("transfer incomplete"); // R5
endmodule

// File: rtl/param_shadow_bank.sv
module param_shadow_bank
  import pbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = PB_DEF_ADDR_W,
  parameter int unsigned DATA_W    = PB_DEF_DATA_W,
  parameter int unsigned CTRL_ADDR = PB_DEF_CTRL_ADDR,
  parameter int unsigned AUTO_BIT  = PB_DEF_AUTO_BIT,
  parameter int unsigned MODE_LSB  = PB_DEF_MODE_LSB,
  localparam int unsigned NWORDS   = 1 << ADDR_W,
  localparam int unsigned FLAT_W   = NWORDS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_n,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 xfer,
  input  logic                 init,
  output logic [FLAT_W-1:0]    work_o,
  output logic [PB_MODE_W-1:0] mode_o
);
  pbank_ctl_t        ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [FLAT_W-1:0] pre_flat;
  logic [DATA_W-1:0] ctrl_word;
  logic              auto_en;
  logic              init_rise;
  logic              load;

  pbank_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer(xfer), .init(init), .ctl_q(ctl_q), .addr_q(addr_q), .data_q(data_q)
  );

  pbank_preload #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pre (
    .clk(clk), .rst(rst), .we(ctl_q.we), .addr(addr_q), .data(data_q),
    .pre_flat(pre_flat)
  );

  assign ctrl_word = work_o[CTRL_ADDR*DATA_W +: DATA_W];
  assign auto_en   = ctrl_word[AUTO_BIT];
  assign init_rise = ctl_q.init & ~ctl_q.init_d;
  assign load      = ctl_q.xfer | (auto_en & init_rise);

  pbank_working #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_work (
    .clk(clk), .rst(rst), .load(load), .pre_flat(pre_flat), .work_flat(work_o)
  );

  assign mode_o = ctrl_word[MODE_LSB +: PB_MODE_W];

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> work_o == '0) else $error("reset left working data"); // R1
  AST_AUTO_TRIGGERS: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.init && !ctl_q.init_d && auto_en) |=> work_o == $past(pre_flat)) else $error("autoload missed"); // R8
  AST_WRITE_NO_LEAK: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.we && !load) |=> $stable(work_o)) else $error("write leaked"); // R4
endmodule

// File: tb/param_shadow_bank_tb_top.sv
module param_shadow_bank_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 12;
  localparam int unsigned NW = 1 << AW;
  localparam int unsigned FW = NW * DW;

  logic clk = 1'b0;
  logic rst, wr_n, xfer, init;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [FW-1:0] work_o;
  logic [1:0]    mode_o;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] pre_m  [NW];
  logic [DW-1:0] work_m [NW];
  logic          p_we, p_xfer, p_init, pp_init;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  param_shadow_bank dut_i (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer(xfer), .init(init), .work_o(work_o), .mode_o(mode_o)
  );

  function automatic logic [FW-1:0] model_flat();
    logic [FW-1:0] f;
    for (int i = 0; i < NW; i++) f[i*DW +: DW] = work_m[i];
    return f;
  endfunction

  // Effect of the inputs sampled one edge earlier.
  task automatic model_step();
    logic go;
    go = p_xfer | (work_m[7][11] & p_init & ~pp_init);
    if (go) for (int i = 0; i < NW; i++) work_m[i] = pre_m[i];
    if (p_we) pre_m[p_addr] = p_data;
    pp_init = p_init;
    p_we = ~wr_n; p_xfer = xfer; p_init = init; p_addr = wr_addr; p_data = wr_data;
  endtask

  task automatic check(string tag);
    checks++;
    if (work_o !== model_flat()) begin
      fails++;
      $display("FAIL %s work_o actual=%h expected=%h", tag, work_o, model_flat());
    end
    checks++;
    if (mode_o !== work_m[7][1:0]) begin
      fails++;
      $display("FAIL R9 mode_o actual=%h expected=%h", mode_o, work_m[7][1:0]);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, then check after the next one.
  task automatic cyc(input logic wn, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic x, input logic in, input string tag);
    wr_n = wn; wr_addr = a; wr_data = d; xfer = x; init = in;
    @(negedge clk);
    model_step();
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, '0, '0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NW; i++) begin pre_m[i] = '0; work_m[i] = '0; end
    p_we = 0; p_xfer = 0; p_init = 0; pp_init = 0; p_addr = '0; p_data = '0;
    rst = 1; wr_n = 1; xfer = 0; init = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset state");
    cyc(1'b1, '0, '0, 1'b1, 1'b0, "R1 transfer after reset");
    idle(1, "R1 zero kept");

    // Writes without transfer: working set unchanged.
    for (int i = 0; i < NW; i++) cyc(1'b0, AW'(i), DW'(12'h100 + i), 1'b0, 1'b0, "R4 write no leak");
    idle(1, "R4 settle");
    // Enable high, random bus: no change.
    for (int i = 0; i < 6; i++) cyc(1'b1, AW'($urandom), DW'($urandom), 1'b0, 1'b0, "R3 disabled write");
    cyc(1'b1, '0, '0, 1'b1, 1'b0, "R2 R5 full transfer");
    idle(2, "R6 hold");

    // Simultaneous write and transfer.
    cyc(1'b0, 4'd3, 12'hABC, 1'b1, 1'b0, "R7 write+xfer");
    idle(1, "R7 old value transferred");
    cyc(1'b1, '0, '0, 1'b1, 1'b0, "R7 second transfer");
    idle(1, "R7 new value seen");

    // Autoload clear: init ignored.
    cyc(1'b0, 4'd5, 12'h555, 1'b0, 1'b0, "R8 stage");
    cyc(1'b1, '0, '0, 1'b0, 1'b1, "R8 init no auto");
    idle(2, "R8 init ignored");
    // Enable autoload with mode 2.
    cyc(1'b0, 4'd7, 12'h802, 1'b0, 1'b0, "R9 stage ctrl");
    cyc(1'b1, '0, '0, 1'b1, 1'b0, "R9 load ctrl");
    idle(1, "R9 mode");
    cyc(1'b0, 4'd5, 12'h777, 1'b0, 1'b0, "R8 stage");
    cyc(1'b0, 4'd9, 12'h999, 1'b0, 1'b0, "R8 stage");
    for (int i = 0; i < 4; i++) cyc(1'b1, '0, '0, 1'b0, 1'b1, "R8 init held");
    cyc(1'b0, 4'd5, 12'h123, 1'b0, 1'b1, "R8 no retrigger");
    idle(3, "R8 single transfer");

    // Random mix.
    for (int n = 0; n < 3000; n++) begin
      cyc(($urandom % 3) == 0, AW'($urandom), DW'($urandom),
          ($urandom % 8) == 0, ($urandom % 6) == 0, "R5 random");
    end
    idle(2, "R6 final");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule